// File: doc/BRIEF.md
# Conversion Result Buffer with Watermark and Window Compare

This block holds conversion results for one converter mode in a small first-in first-out store. A producer strobes each new result in; a consumer pops the oldest result. Software-visible raw flags come out directly: a data-valid flag that rises once enough unread results are waiting, a sticky overflow flag for writes that meet a full store, and a sticky compare flag that records when a result lands in (or out of) a programmable window.

When the store is full, a policy input chooses between discarding the incoming result and replacing the oldest one. A peek output always shows the most recently accepted result without removing anything. The window comparator tests every write strobe against two thresholds. Their relative order selects inside-window or outside-window detection.

Top module: `conv_result_buffer`

## Requirements
- R1: After reset `level` is 0, `data_valid`, `ovf_flag` and `cmp_flag` are 0, and `rd_data` and `peek_data` are 0. `level` never exceeds DEPTH (default 4).
- R2: Results leave in the order they were accepted. `rd_data` shows the oldest unread result, or 0 while `level` is 0. A pop (`rd_en`) removes it at the next clock edge.
- R3: `data_valid` is 1 exactly when `level` is at least `wm_level`+1 (`wm_level` 0..3 means 1..4 results). It follows `level` in the same cycle.
- R4: With `ovf_replace`=0, a write to a full store that has no pop in the same cycle is discarded: contents, `level` and `peek_data` are unchanged.
- R5: With `ovf_replace`=1, a write to a full store that has no pop in the same cycle overwrites the oldest result. `level` stays at DEPTH, and the next result becomes the new oldest.
- R6: A write to a full store that has no pop in the same cycle sets `ovf_flag` under either policy. The flag holds until `ovf_clr`; a set in the same cycle as `ovf_clr` wins.
- R7: `peek_data` equals the last accepted (stored or overwriting) result. It is not changed by pops or by discarded writes.
- R8: When `cmp_en`=1 and `thr_gt` <= `thr_lt`, a write strobe whose value is strictly greater than `thr_gt` and strictly less than `thr_lt` sets `cmp_flag`.
- R9: When `cmp_en`=1 and `thr_gt` > `thr_lt`, a write strobe whose value is strictly greater than `thr_gt` or strictly less than `thr_lt` sets `cmp_flag`.
- R10: `cmp_flag` is sticky until `cmp_clr`; a hit in the same cycle as `cmp_clr` wins. The flag is not set while `cmp_en`=0.
- R11: A write and a pop in the same cycle on a non-empty store leave `level` unchanged. On a full store this is not an overflow. A pop on an empty store is ignored, so a write with it makes `level` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a new result |
| wr_data | input | DATA_W | New result value |
| rd_en | input | 1 | Pop strobe for the oldest result |
| ovf_replace | input | 1 | Full policy: 0 discard new, 1 overwrite oldest |
| wm_level | input | PTR_W | Watermark, value n means n+1 results |
| ovf_clr | input | 1 | Clears the overflow flag |
| cmp_en | input | 1 | Enables the window comparator |
| thr_gt | input | DATA_W | Greater-than threshold |
| thr_lt | input | DATA_W | Less-than threshold |
| cmp_clr | input | 1 | Clears the compare flag |
| rd_data | output | DATA_W | Oldest unread result, 0 when empty |
| peek_data | output | DATA_W | Most recently accepted result |
| level | output | CNT_W | Number of unread results |
| data_valid | output | 1 | Watermark reached |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky window-compare flag |

## Verification
A pop and a write can meet in one cycle. The hard case is a full store, where the pop must free the slot so the write is accepted with no overflow and no replacement. The bench drives both strobes on the same clock edge while the store holds four results. It then checks that `level` stays at four, that the head advanced to the second-oldest value, that `peek_data` took the new value and that `ovf_flag` stayed low. The same edge-sharing is applied to both sticky flags: a set and its clear are asserted together, and the flag is expected to read 1 afterwards.

// File: rtl/crb_pkg.sv
package crb_pkg;
    typedef enum logic {
        FULL_DISCARD = 1'b0,
        FULL_REPLACE = 1'b1
    } full_policy_e;
endpackage

// File: rtl/crb_store.sv
module crb_store
    import crb_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  full_policy_e      policy,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] head_data,
    output logic [DATA_W-1:0] peek_data,
    output logic [CNT_W-1:0]  level,
    output logic              ovf_flag
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [CNT_W-1:0]             cnt;
        logic [DATA_W-1:0]            last;
        logic                         ovf;
    } store_t;

    store_t st_d, st_q;

    logic is_full, is_empty, pop_ok, push_ok, overrun, replace;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        is_full  = (st_q.cnt == CNT_W'(DEPTH));
        is_empty = (st_q.cnt == '0);
        pop_ok   = rd_en && !is_empty;
        push_ok  = wr_en && (!is_full || pop_ok);
        overrun  = wr_en && is_full && !pop_ok;
        replace  = overrun && (policy == FULL_REPLACE);

        st_d = st_q;
        if (push_ok || replace) begin
            st_d.mem[st_q.wptr] = wr_data;
            st_d.wptr           = ptr_step(st_q.wptr);
            st_d.last           = wr_data;
        end
        if (pop_ok || replace) begin
            st_d.rptr = ptr_step(st_q.rptr);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (overrun) begin
            st_d.ovf = 1'b1;
        end else if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_data = is_empty ? '0 : st_q.mem[st_q.rptr];
    assign peek_data = st_q.last;
    assign level     = st_q.cnt;
    assign ovf_flag  = st_q.ovf;

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    p_discard_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_full && !rd_en && policy == FULL_DISCARD)
        |=> ($stable(st_q.mem) && $stable(level) && $stable(peek_data)));

    p_replace_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_full && !rd_en && policy == FULL_REPLACE)
        |=> (level == CNT_W'(DEPTH) && peek_data == $past(wr_data)));

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_full && !rd_en) |=> ovf_flag);

    p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_peek_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(peek_data));

    p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !is_empty) |=> $stable(level));

    p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && is_empty) |=> (level == '0));
endmodule

// File: rtl/crb_level_flag.sv
module crb_level_flag #(
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] level,
    input  logic [PTR_W-1:0] wm_level,
    output logic             data_valid
);
    logic [CNT_W-1:0] wm_ext;

    always_comb begin
        wm_ext     = CNT_W'(wm_level);
        data_valid = (level > wm_ext);
    end
endmodule

// File: rtl/crb_window.sv
module crb_window #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] sample,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] thr_gt,
    input  logic [DATA_W-1:0] thr_lt,
    input  logic              cmp_clr,
    output logic              cmp_flag
);
    typedef struct packed {
        logic hit;
    } win_t;

    win_t win_d, win_q;
    logic above, below, inside_mode, hit_now;

    always_comb begin
        above       = (sample > thr_gt);
        below       = (sample < thr_lt);
        inside_mode = (thr_gt <= thr_lt);
        hit_now     = sample_en && cmp_en &&
                      (inside_mode ? (above && below) : (above || below));

        win_d = win_q;
        if (hit_now) begin
            win_d.hit = 1'b1;
        end else if (cmp_clr) begin
            win_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign cmp_flag = win_q.hit;

    p_cmp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !cmp_clr) |=> cmp_flag);

    p_cmp_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_flag && !cmp_en) |=> !cmp_flag);

    p_inside_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && cmp_en && thr_gt <= thr_lt && sample > thr_gt && sample < thr_lt)
        |=> cmp_flag);

    p_outside_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && cmp_en && thr_gt > thr_lt && (sample > thr_gt || sample < thr_lt))
        |=> cmp_flag);
endmodule

// File: rtl/conv_result_buffer.sv
module conv_result_buffer
    import crb_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              ovf_replace,
    input  logic [PTR_W-1:0]  wm_level,
    input  logic              ovf_clr,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] thr_gt,
    input  logic [DATA_W-1:0] thr_lt,
    input  logic              cmp_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] peek_data,
    output logic [CNT_W-1:0]  level,
    output logic              data_valid,
    output logic              ovf_flag,
    output logic              cmp_flag
);
    full_policy_e policy;
    assign policy = full_policy_e'(ovf_replace);

    crb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .policy    (policy),
        .ovf_clr   (ovf_clr),
        .head_data (rd_data),
        .peek_data (peek_data),
        .level     (level),
        .ovf_flag  (ovf_flag)
    );

    crb_level_flag #(.DEPTH(DEPTH)) u_level_flag (
        .level      (level),
        .wm_level   (wm_level),
        .data_valid (data_valid)
    );

    crb_window #(.DATA_W(DATA_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (wr_en),
        .sample    (wr_data),
        .cmp_en    (cmp_en),
        .thr_gt    (thr_gt),
        .thr_lt    (thr_lt),
        .cmp_clr   (cmp_clr),
        .cmp_flag  (cmp_flag)
    );

    p_dv_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (level != '0));

    p_full_pop_no_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && level == CNT_W'(DEPTH) && !ovf_flag && !ovf_clr) |=> !ovf_flag);
endmodule

// File: tb/conv_result_buffer_tb_top.sv
module conv_result_buffer_tb_top;
    localparam int DATA_W = 12;
    localparam int DEPTH  = 4;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              ovf_replace = 1'b0;
    logic [PTR_W-1:0]  wm_level = '0;
    logic              ovf_clr = 1'b0;
    logic              cmp_en = 1'b0;
    logic [DATA_W-1:0] thr_gt = '0;
    logic [DATA_W-1:0] thr_lt = '0;
    logic              cmp_clr = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] peek_data;
    logic [CNT_W-1:0]  level;
    logic              data_valid;
    logic              ovf_flag;
    logic              cmp_flag;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    conv_result_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .ovf_replace(ovf_replace), .wm_level(wm_level),
        .ovf_clr(ovf_clr), .cmp_en(cmp_en), .thr_gt(thr_gt), .thr_lt(thr_lt),
        .cmp_clr(cmp_clr), .rd_data(rd_data), .peek_data(peek_data),
        .level(level), .data_valid(data_valid), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [11:0] wdata;
        logic [2:0]  lvl;
        logic        dv;
        logic [11:0] head;
        logic [11:0] peek;
    } vec_t;

    // watermark 1 (two results), discard policy; expected values after the edge
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 12'h111, 3'd1, 1'b0, 12'h111, 12'h111},
        '{1'b1, 1'b0, 12'h222, 3'd2, 1'b1, 12'h111, 12'h222},
        '{1'b1, 1'b1, 12'h333, 3'd2, 1'b1, 12'h222, 12'h333},
        '{1'b0, 1'b1, 12'h000, 3'd1, 1'b0, 12'h333, 12'h333},
        '{1'b0, 1'b1, 12'h000, 3'd0, 1'b0, 12'h000, 12'h333},
        '{1'b0, 1'b1, 12'h000, 3'd0, 1'b0, 12'h000, 12'h333},
        '{1'b1, 1'b1, 12'h444, 3'd1, 1'b0, 12'h444, 12'h444},
        '{1'b1, 1'b0, 12'h555, 3'd2, 1'b1, 12'h444, 12'h555},
        '{1'b1, 1'b0, 12'h666, 3'd3, 1'b1, 12'h444, 12'h666},
        '{1'b1, 1'b0, 12'h777, 3'd4, 1'b1, 12'h444, 12'h777},
        '{1'b1, 1'b1, 12'h888, 3'd4, 1'b1, 12'h555, 12'h888},
        '{1'b0, 1'b0, 12'h000, 3'd4, 1'b1, 12'h555, 12'h888}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        ovf_clr = 1'b0;
        cmp_clr = 1'b0;
    endtask

    task automatic put(input logic [DATA_W-1:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step();
    endtask

    task automatic pop();
        rd_en = 1'b1;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "level", 32'(level), 0);
        chk("R1", "data_valid", 32'(data_valid), 0);
        chk("R1", "ovf_flag", 32'(ovf_flag), 0);
        chk("R1", "cmp_flag", 32'(cmp_flag), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
        chk("R1", "peek_data", 32'(peek_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2 R3 R7 R11
        wm_level = 2'd1;
        for (int i = 0; i < NV; i++) begin
            wr_en   = VECS[i].wr;
            rd_en   = VECS[i].rd;
            wr_data = VECS[i].wdata;
            step();
            chk("R11", "level", 32'(level), 32'(VECS[i].lvl));
            chk("R3", "data_valid", 32'(data_valid), 32'(VECS[i].dv));
            chk("R2", "rd_data", 32'(rd_data), 32'(VECS[i].head));
            chk("R7", "peek_data", 32'(peek_data), 32'(VECS[i].peek));
        end
        chk("R11", "no ovf on full write+pop", 32'(ovf_flag), 0);

        // R4 discard on full
        put(12'h999);
        chk("R4", "level", 32'(level), 4);
        chk("R4", "rd_data", 32'(rd_data), 12'h555);
        chk("R4", "peek_data", 32'(peek_data), 12'h888);
        chk("R6", "ovf set", 32'(ovf_flag), 1);
        step();
        chk("R6", "ovf holds", 32'(ovf_flag), 1);
        ovf_clr = 1'b1;
        step();
        chk("R6", "ovf cleared", 32'(ovf_flag), 0);

        // R5 overwrite oldest
        ovf_replace = 1'b1;
        put(12'haaa);
        chk("R5", "level", 32'(level), 4);
        chk("R5", "new head", 32'(rd_data), 12'h666);
        chk("R5", "peek_data", 32'(peek_data), 12'haaa);
        chk("R6", "ovf set on replace", 32'(ovf_flag), 1);
        // R6 set beats clear in one cycle
        wr_en = 1'b1; wr_data = 12'hbbb; ovf_clr = 1'b1;
        step();
        chk("R6", "set wins over clear", 32'(ovf_flag), 1);
        chk("R5", "head after second replace", 32'(rd_data), 12'h777);
        pop();
        chk("R2", "order 1", 32'(rd_data), 12'h888);
        pop();
        chk("R2", "order 2", 32'(rd_data), 12'haaa);
        pop();
        chk("R2", "order 3", 32'(rd_data), 12'hbbb);
        pop();
        chk("R2", "empty head", 32'(level), 0);
        chk("R2", "empty rd_data", 32'(rd_data), 0);
        chk("R7", "peek survives pops", 32'(peek_data), 12'hbbb);
        ovf_replace = 1'b0;
        ovf_clr = 1'b1;
        step();

        // R3 watermark edges
        wm_level = 2'd3;
        put(12'h001); put(12'h002); put(12'h003);
        chk("R3", "3 of 4 not valid", 32'(data_valid), 0);
        put(12'h004);
        chk("R3", "4 of 4 valid", 32'(data_valid), 1);
        wm_level = 2'd0;
        #1;
        chk("R3", "wm 0 valid", 32'(data_valid), 1);
        pop(); pop(); pop(); pop();
        chk("R3", "empty not valid", 32'(data_valid), 0);

        // R8 inside window
        cmp_en = 1'b1; thr_gt = 12'd100; thr_lt = 12'd200;
        put(12'd100);
        chk("R8", "boundary low no hit", 32'(cmp_flag), 0);
        put(12'd250);
        chk("R8", "above window no hit", 32'(cmp_flag), 0);
        put(12'd150);
        chk("R8", "inside hit", 32'(cmp_flag), 1);
        step();
        chk("R10", "sticky", 32'(cmp_flag), 1);
        cmp_clr = 1'b1;
        step();
        chk("R10", "cleared", 32'(cmp_flag), 0);

        // R9 outside window
        thr_gt = 12'd200; thr_lt = 12'd100;
        put(12'd150);
        chk("R9", "inside no hit", 32'(cmp_flag), 0);
        put(12'd200);
        chk("R9", "boundary no hit", 32'(cmp_flag), 0);
        put(12'd50);
        chk("R9", "below hit", 32'(cmp_flag), 1);
        cmp_clr = 1'b1;
        step();
        wr_en = 1'b1; wr_data = 12'd300; cmp_clr = 1'b1;
        step();
        chk("R10", "hit wins over clear", 32'(cmp_flag), 1);
        cmp_clr = 1'b1;
        step();
        cmp_en = 1'b0;
        put(12'd50);
        chk("R10", "disabled no hit", 32'(cmp_flag), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule